// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a synchronous requester and an external asynchronous static RAM with 32768 eight-bit words. It accepts one read or one write at a time and turns it into a sequence of active-low chip-select, write-strobe and output-enable levels. The address and the write word stay fixed on the memory pins for the whole access. The RAM has one shared bidirectional data bus. The controller drives it through separate out, in and drive-enable signals, and a pad ring resolves them.

Every timing window is a count of clock cycles. Each count comes from a nanosecond parameter, divided by the clock period and rounded up. The read window is the longest of the address access, output-enable access and minimum cycle times. The write pulse is the longest of the strobe width, data setup, address-to-end, select-to-end and minimum cycle times.

After a read, the RAM may keep driving the bus for a short time once output enable rises. The controller counts this release time before it drives write data. A write that arrives during that time waits and drives nothing.

Requests use a valid/ready handshake. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The requester may hold `req_valid` high for as long as it needs, and `req_ready` is high only while the controller is idle. Read results are a one-cycle pulse that cannot be held back. The requester must take `rsp_data` in the cycle `rsp_valid` is high.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1 and `mem_dq_oe` is 0. `req_ready` is 1 only in that state. `rsp_valid` is 0 after reset.
- R2: The strobes (ce_n, we_n, oe_n) take only these values: (1,1,1) idle, (0,1,0) read, (0,0,1) write pulse, (0,1,1) post-write hold. we_n and oe_n are never low together, and neither is low while ce_n is high.
- R3: A read holds ce_n and oe_n low together for exactly RD_CYC consecutive cycles, with `mem_addr` equal to the accepted address. RD_CYC is the largest of ceil(T_AA_NS/P), ceil(T_OE_NS/P) and ceil(T_CYCLE_NS/P), where P is CLK_PERIOD_NS.
- R4: `rsp_data` is the value of `mem_dq_in` sampled on the clock edge that ends the RD_CYC window. `rsp_valid` is 1 for exactly one cycle, the cycle right after oe_n rises. For a read accepted on edge a, that cycle starts at edge a+RD_CYC.
- R5: A write holds we_n low, with ce_n low and oe_n high, for exactly WR_CYC consecutive cycles. WR_CYC is the largest of the rounded-up T_WP_NS, T_DS_NS, T_AW_NS, T_CW_NS and T_CYCLE_NS. Throughout the pulse, `mem_addr` and `mem_dq_out` equal the accepted address and data and do not change.
- R6: `mem_dq_oe` is 1 in every cycle that we_n is low and in the one cycle after we_n rises. It is 0 in the cycle after that.
- R7: Once oe_n rises, `mem_dq_oe` stays 0 for at least REL_CYC = ceil(T_REL_NS/P) cycles. A write delayed only by this rule starts its pulse exactly REL_CYC cycles after oe_n rose.
- R8: Request fields are sampled only on the accepting edge. Later changes to `req_*`, and any request while `req_valid` is 0, leave `mem_addr`, `mem_dq_out` and the strobes unchanged. While ce_n stays low, `mem_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (15) | Word address |
| req_wdata | input | DATA_W (8) | Write word |
| rsp_valid | output | 1 | One-cycle pulse: read word available |
| rsp_data | output | DATA_W (8) | Captured read word |
| mem_ce_n | output | 1 | Chip select to RAM, active low |
| mem_we_n | output | 1 | Write strobe to RAM, active low |
| mem_oe_n | output | 1 | Output enable to RAM, active low |
| mem_addr | output | ADDR_W (15) | Address to RAM |
| mem_dq_out | output | DATA_W (8) | Data toward the shared bus |
| mem_dq_in | input | DATA_W (8) | Data from the shared bus |
| mem_dq_oe | output | 1 | Controller drives the shared bus |

## Verification
Three things can happen in the same cycle: the read response pulse, the acceptance of the next request, and the bus release window still running from the read. The bench provokes this by raising a write request while a read is still in flight. That write is then accepted in the very cycle `rsp_valid` is high. The bench judges the outcome in three ways. The read word must be correct. The write pulse must begin exactly REL_CYC cycles after output enable rose. A bus model must see no cycle in which both sides could drive the data lines.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD       = 3'd1,
    ST_WR_WAIT  = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_WR_HOLD  = 3'd4
  } ctrl_state_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Loadable down counter that stops at zero.
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/sram_strobe_fsm.sv
`timescale 1ns/1ps
// Sequencer: chooses the phase and decodes the strobe levels from it.
module sram_strobe_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int RD_LOAD = 6,
  parameter int WR_LOAD = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             phase_zero,
  input  logic             rel_ok,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             rel_load,
  output logic             phase_load,
  output logic [CNT_W-1:0] phase_val,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);

  localparam logic [CNT_W-1:0] RD_VAL = CNT_W'(RD_LOAD);
  localparam logic [CNT_W-1:0] WR_VAL = CNT_W'(WR_LOAD);

  ctrl_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    accept     = 1'b0;
    capture    = 1'b0;
    rel_load   = 1'b0;
    phase_load = 1'b0;
    phase_val  = RD_VAL;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (!req_write) begin
            state_d    = ST_RD;
            phase_load = 1'b1;
            phase_val  = RD_VAL;
          end else if (rel_ok) begin
            state_d    = ST_WR_PULSE;
            phase_load = 1'b1;
            phase_val  = WR_VAL;
          end else begin
            state_d = ST_WR_WAIT;
          end
        end
      end
      ST_RD: begin
        if (phase_zero) begin
          capture  = 1'b1;
          rel_load = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_WR_WAIT: begin
        if (rel_ok) begin
          state_d    = ST_WR_PULSE;
          phase_load = 1'b1;
          phase_val  = WR_VAL;
        end
      end
      ST_WR_PULSE: begin
        if (phase_zero) state_d = ST_WR_HOLD;
      end
      ST_WR_HOLD: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    ce_n      = !((state_q == ST_RD) || (state_q == ST_WR_PULSE) || (state_q == ST_WR_HOLD));
    oe_n      = (state_q != ST_RD);
    we_n      = (state_q != ST_WR_PULSE);
    dq_oe     = (state_q == ST_WR_PULSE) || (state_q == ST_WR_HOLD);
  end

endmodule

// File: rtl/sram_req_path.sv
`timescale 1ns/1ps
// Request holding registers and read capture.
module sram_req_path #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_data <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_CYCLE_NS    = 35,
  parameter int T_WP_NS       = 20,
  parameter int T_DS_NS       = 15,
  parameter int T_AW_NS       = 20,
  parameter int T_CW_NS       = 25,
  parameter int T_AA_NS       = 35,
  parameter int T_OE_NS       = 15,
  parameter int T_REL_NS      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int unsigned P = CLK_PERIOD_NS;
  localparam int unsigned RD_CYC = max2(max2(ns_to_cyc(T_AA_NS, P), ns_to_cyc(T_OE_NS, P)),
                                        max2(ns_to_cyc(T_CYCLE_NS, P), 1));
  localparam int unsigned WR_CYC = max2(max2(max2(ns_to_cyc(T_WP_NS, P), ns_to_cyc(T_DS_NS, P)),
                                             max2(ns_to_cyc(T_AW_NS, P), ns_to_cyc(T_CW_NS, P))),
                                        max2(ns_to_cyc(T_CYCLE_NS, P), 1));
  localparam int unsigned REL_CYC = ns_to_cyc(T_REL_NS, P);
  localparam int CNT_W = $clog2(max2(max2(RD_CYC, WR_CYC), REL_CYC) + 1);

  logic             accept, capture, rel_load, phase_load, rel_ok;
  logic [CNT_W-1:0] phase_val, phase_cnt;

  sram_strobe_fsm #(
    .CNT_W  (CNT_W),
    .RD_LOAD(int'(RD_CYC) - 1),
    .WR_LOAD(int'(WR_CYC) - 1)
  ) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .phase_zero(phase_cnt == '0),
    .rel_ok    (rel_ok),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .rel_load  (rel_load),
    .phase_load(phase_load),
    .phase_val (phase_val),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dq_oe     (mem_dq_oe)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) i_phase_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (phase_load),
    .load_val(phase_val),
    .cnt     (phase_cnt)
  );

  generate
    if (REL_CYC == 0) begin : g_no_release
      assign rel_ok = 1'b1;
      logic unused_rel;
      assign unused_rel = rel_load;
    end else begin : g_release
      logic [CNT_W-1:0] rel_cnt;
      sram_phase_timer #(.CNT_W(CNT_W)) i_release_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rel_load),
        .load_val(CNT_W'(REL_CYC)),
        .cnt     (rel_cnt)
      );
      // driving may start on the edge that completes the release count
      assign rel_ok = (rel_cnt <= CNT_W'(1));
    end
  endgenerate

  sram_req_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_req_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_REL_NS      = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  localparam int unsigned REL_CYC = ns_to_cyc(T_REL_NS, CLK_PERIOD_NS);

  // cycles since output enable last went high, saturating
  logic [7:0] since_oe;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_oe <= 8'hFF;
    else if (!mem_oe_n)      since_oe <= 8'h00;
    else if (since_oe != 8'hFF) since_oe <= since_oe + 8'h01;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
  AST_NO_WE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R2
  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R2
  AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n); // R2
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_oe_n && $past(!mem_oe_n))); // R4
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R5
  AST_DRIVE_COVERS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe); // R6
  AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe); // R6
  AST_DRIVE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_dq_oe) && $past(mem_we_n) && mem_we_n) |-> !mem_dq_oe); // R6
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (since_oe >= 8'(REL_CYC))); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R8
  AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_REL_NS     (T_REL_NS)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_addr  (mem_addr),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;

  // timing counts are evaluated for a 5 ns period to stretch every window
  localparam int PER = 5;
  function automatic int cdiv(input int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int B_RD  = mx(mx(cdiv(35), cdiv(15)), cdiv(35));
  localparam int B_WR  = mx(mx(mx(cdiv(20), cdiv(15)), mx(cdiv(20), cdiv(25))), cdiv(35));
  localparam int B_REL = cdiv(12);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [14:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #10 clk = ~clk;

  sram_strobe_ctrl #(.CLK_PERIOD_NS(PER)) i_sram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  // ---------------- memory model ----------------
  logic [7:0]  model [64];
  logic [14:0] wr_addr_seen, rd_addr_seen;
  int          age;

  always @(posedge mem_we_n) begin
    if (mem_ce_n == 1'b0) begin
      model[mem_addr[5:0]] = mem_dq_out;
      wr_addr_seen = mem_addr;
    end
  end

  // data appears on the bus only once the access time has elapsed
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n && age >= B_RD - 1)
                     ? model[mem_addr[5:0]] : 8'hEE;

  // ---------------- monitors (sample values from before the edge) ----------------
  int oe_run, last_oe_run, we_run, last_we_run;
  int since_oe, first_gap, conflicts, hold_err, addr_err, combo_err;
  bit prev_we, prev_dq_oe, prev_hold, prev_ce_low;
  logic [14:0] prev_addr;

  initial begin
    age = 0; oe_run = 0; last_oe_run = 0; we_run = 0; last_we_run = 0;
    since_oe = 1000; first_gap = -1; conflicts = 0; hold_err = 0; addr_err = 0;
    combo_err = 0; prev_we = 1'b1; prev_dq_oe = 1'b0; prev_hold = 1'b0;
    prev_ce_low = 1'b0; prev_addr = '0;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      bit hold_now;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) age = age + 1; else age = 0;
      if (!mem_ce_n && !mem_oe_n) begin oe_run++; rd_addr_seen = mem_addr; end
      else if (oe_run != 0) begin last_oe_run = oe_run; oe_run = 0; end
      if (!mem_we_n) we_run++;
      else if (we_run != 0) begin last_we_run = we_run; we_run = 0; end
      if ((!mem_we_n && !mem_oe_n) || (mem_ce_n && (!mem_we_n || !mem_oe_n))) combo_err++;
      if (mem_dq_oe && (!mem_oe_n || since_oe < B_REL)) conflicts++;
      if (mem_dq_oe && !prev_dq_oe) first_gap = since_oe;
      if (!mem_oe_n) since_oe = 0; else if (since_oe < 1000) since_oe++;
      hold_now = !prev_we && mem_we_n;
      if (hold_now && !mem_dq_oe) hold_err++;
      if (prev_hold && mem_dq_oe) hold_err++;
      if (!mem_we_n && !mem_dq_oe) hold_err++;
      prev_hold = hold_now;
      if (!mem_ce_n && prev_ce_low && mem_addr != prev_addr) addr_err++;
      prev_ce_low = !mem_ce_n;
      prev_addr   = mem_addr;
      prev_we     = mem_we_n;
      prev_dq_oe  = mem_dq_oe;
    end
  end

  // ---------------- checking helpers ----------------
  int  checks = 0, errors = 0;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = ~w; req_addr = ~a; req_wdata = ~d;
  endtask

  task automatic finish_read(input logic [14:0] a, input logic [7:0] exp_d);
    int n = 1;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    chk(n == B_RD + 1, "R4", "cycles accept to rsp_valid", n, B_RD + 1);
    chk(rsp_data == exp_d, "R4", "read word", rsp_data, exp_d);
    @(negedge clk);
    chk(!rsp_valid, "R4", "rsp_valid width", rsp_valid, 0);
    chk(last_oe_run == B_RD, "R3", "oe_n low cycles", last_oe_run, B_RD);
    chk(rd_addr_seen == a, "R3", "read address", rd_addr_seen, a);
  endtask

  task automatic finish_write(input logic [14:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    chk(last_we_run == B_WR, "R5", "we_n low cycles", last_we_run, B_WR);
    chk(wr_addr_seen == a, "R5", "write address", wr_addr_seen, a);
    chk(model[a[5:0]] == d, "R5", "stored word", model[a[5:0]], d);
  endtask

  // stimulus table: {write, addr[14:0], data}; for reads, data is the expected word
  localparam logic [23:0] VEC [8] = '{
    {1'b1, 15'h0001, 8'hA5},
    {1'b1, 15'h7FC2, 8'h3C},
    {1'b1, 15'h4003, 8'hFF},
    {1'b0, 15'h0001, 8'hA5},
    {1'b0, 15'h7FC2, 8'h3C},
    {1'b1, 15'h0001, 8'h5A},
    {1'b0, 15'h0001, 8'h5A},
    {1'b0, 15'h4003, 8'hFF}
  };

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes after reset",
        {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!mem_dq_oe && req_ready && !rsp_valid, "R1", "bus/ready/rsp after reset",
        {mem_dq_oe, req_ready, rsp_valid}, 3'b010);

    // R8: inputs wiggling with req_valid low have no effect
    begin
      int busy = 0;
      for (int i = 0; i < 6; i++) begin
        req_addr = 15'(i * 977); req_wdata = 8'(i * 31); req_write = i[0];
        @(negedge clk);
        if (!mem_ce_n || !mem_we_n || !mem_oe_n || mem_dq_oe) busy++;
      end
      chk(busy == 0, "R8", "strobes with req_valid low", busy, 0);
      chk(mem_addr == 15'h0 && mem_dq_out == 8'h0, "R8", "pins untouched without valid",
          {mem_addr, mem_dq_out}, 0);
    end

    // table walk
    for (int v = 0; v < 8; v++) begin
      issue(VEC[v][23], VEC[v][22:8], VEC[v][7:0]);
      if (VEC[v][23]) finish_write(VEC[v][22:8], VEC[v][7:0]);
      else            finish_read(VEC[v][22:8], VEC[v][7:0]);
    end

    // read immediately followed by a write: accept coincides with rsp pulse,
    // write must wait out the bus release
    begin
      int n = 1;
      issue(1'b0, 15'h7FC2, 8'h00);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h1005; req_wdata = 8'h77;
      while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
      chk(n == B_RD + 1, "R4", "rsp timing with pending write", n, B_RD + 1);
      chk(rsp_data == 8'h3C, "R4", "read word with pending write", rsp_data, 8'h3C);
      chk(req_ready, "R1", "ready during rsp cycle", req_ready, 1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_addr = 15'h2AAA; req_wdata = 8'h11;
      chk(mem_dq_oe == 1'b0, "R7", "no drive right after read", mem_dq_oe, 0);
      finish_write(15'h1005, 8'h77);
      chk(first_gap == B_REL, "R7", "release cycles before drive", first_gap, B_REL);
      chk(conflicts == 0, "R7", "bus contention cycles", conflicts, 0);
      issue(1'b0, 15'h1005, 8'h00);
      finish_read(15'h1005, 8'h77);
    end

    repeat (3) @(negedge clk);
    chk(hold_err == 0, "R6", "drive window errors", hold_err, 0);
    chk(combo_err == 0, "R2", "illegal strobe combinations", combo_err, 0);
    chk(addr_err == 0, "R8", "address changes under select", addr_err, 0);
    chk(conflicts == 0, "R7", "total contention cycles", conflicts, 0);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1", "idle at end",
        {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b11110);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule